// File: doc/BRIEF.md
# Keyboard Port Gate Sequence Trap

This block sits beside the host I/O decoder and sees every cycle aimed at the legacy keyboard controller, on either the data port (60h) or the command port (64h). For each cycle it decides at once whether the cycle may continue to the downstream keyboard controller. It also decides whether a one-clock system management interrupt (SMI) pulse should follow.

Most of the time the decision comes from a trap enable bit that belongs to the cycle's type. A trapped cycle is blocked and raises an SMI. The block also follows the address-line-20 gate command sequence: a command byte D1h, then a data byte, then a closing FFh command. Cycles that belong to this sequence pass through even when their trap bit is set. A separate enable bit raises an SMI whenever a sequence closes, whether it closes properly or not. A busy flag shows that a sequence is open.

Top module: `kbd_gate_trap`

## Requirements
- R1: In the idle state, a write of D1h to the command port (`acc_cmd_port`=1, `acc_wr`=1) opens the sequence. The cycle is passed through with no SMI, and `seq_busy` becomes 1.
- R2: In the idle state, every other access stays idle and is governed by its trap bit: `cfg[3]` for a command write, `cfg[2]` for a command read, `cfg[1]` for a data write, `cfg[0]` for a data read. A set bit blocks the cycle (`pass_thru`=0) and raises an SMI. A clear bit passes the cycle with no SMI.
- R3: After D1h, a data-port write of any value advances to the second stage. It is passed through even with `cfg[1]` set, raises no SMI, and keeps `seq_busy` at 1.
- R4: After D1h, a repeated D1h command write keeps the first stage. It is passed through even with `cfg[3]` set, raises no SMI, and keeps `seq_busy` at 1.
- R5: With a sequence open, a command-port read keeps the current stage and leaves `seq_busy` at 1. It is blocked and raises an SMI only when `cfg[2]` is set.
- R6: In the second stage, a command write of FFh closes the sequence. It is always passed through and clears `seq_busy`. It raises an SMI exactly when `cfg[7]` is set.
- R7: Any other access with a sequence open closes it improperly and clears `seq_busy`. This covers a non-matching command write, a data read, or a data write in the second stage. The cycle's own trap bit decides blocking and SMI, and `cfg[7]` set adds an SMI.
- R8: `pass_thru` is combinational and is high only while `acc_vld` is high. The SMI pulse lasts one clock and appears in the cycle after the strobe. `seq_busy` updates on that same edge. Without a strobe there is no pass, no SMI and no change of `seq_busy`.
- R9: A synchronous active-low reset returns the block to idle with `seq_busy` and `smi_pulse` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_vld | input | 1 | One-clock strobe marking a keyboard port cycle |
| acc_cmd_port | input | 1 | 1 = command port 64h, 0 = data port 60h |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_data | input | 8 | Write data byte, used on writes only |
| cfg | input | 8 | Trap enables, bits 0..3, and end-of-sequence SMI enable, bit 7 |
| pass_thru | output | 1 | Cycle may go on to the keyboard controller |
| smi_pulse | output | 1 | One-clock SMI request |
| seq_busy | output | 1 | Gate sequence in progress |

## Verification
The embedded assertions hold on every cycle for several properties: no pass and no SMI without a strobe, and a busy flag that does not change while the port is quiet. They also check that the opening D1h write always passes without an SMI, that the first-stage data write always passes, and that the closing FFh write passes and clears the busy flag. Two things show up only in the bench's scenarios, because they depend on the exact sequence of accesses that came before: how trap bits are overridden or applied stage by stage, and the extra SMI on improper closes. The bench also covers back-to-back strobes, repeated D1h, a reset in the middle of a sequence, and closes that use each access type.

// File: rtl/kbd_gate_trap.sv
module kbd_gate_trap #(
  parameter logic [7:0] GATE_CMD    = 8'hD1,
  parameter logic [7:0] END_CMD     = 8'hFF,
  parameter int         TRAP_CMD_WR = 3,
  parameter int         TRAP_CMD_RD = 2,
  parameter int         TRAP_DAT_WR = 1,
  parameter int         TRAP_DAT_RD = 0,
  parameter int         END_SMI_BIT = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_vld,
  input  logic       acc_cmd_port,
  input  logic       acc_wr,
  input  logic [7:0] acc_data,
  input  logic [7:0] cfg,
  output logic       pass_thru,
  output logic       smi_pulse,
  output logic       seq_busy
);

  typedef enum logic [1:0] {S_IDLE, S_GATE1, S_GATE2} seq_t;

  seq_t st_q, st_d;
  logic smi_q, use_trap, end_smi, type_trap, trap;
  logic cmd_wr, cmd_rd, dat_wr, dat_rd, is_gate, is_end;

  assign cmd_wr  = acc_vld &  acc_cmd_port &  acc_wr;
  assign cmd_rd  = acc_vld &  acc_cmd_port & ~acc_wr;
  assign dat_wr  = acc_vld & ~acc_cmd_port &  acc_wr;
  assign dat_rd  = acc_vld & ~acc_cmd_port & ~acc_wr;
  assign is_gate = cmd_wr & (acc_data == GATE_CMD);
  assign is_end  = cmd_wr & (acc_data == END_CMD);

  assign type_trap = (cmd_wr & cfg[TRAP_CMD_WR]) | (cmd_rd & cfg[TRAP_CMD_RD]) |
                     (dat_wr & cfg[TRAP_DAT_WR]) | (dat_rd & cfg[TRAP_DAT_RD]);

  always_comb begin
    st_d     = st_q;
    use_trap = 1'b1;
    end_smi  = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (is_gate) begin
          st_d     = S_GATE1;
          use_trap = 1'b0;
        end
      end
      S_GATE1: begin
        if (dat_wr) begin
          st_d     = S_GATE2;
          use_trap = 1'b0;
        end else if (is_gate) begin
          use_trap = 1'b0;
        end else if (cmd_wr || dat_rd) begin
          st_d    = S_IDLE;
          end_smi = cfg[END_SMI_BIT];
        end
      end
      S_GATE2: begin
        if (is_end) begin
          st_d     = S_IDLE;
          use_trap = 1'b0;
          end_smi  = cfg[END_SMI_BIT];
        end else if (acc_vld && !cmd_rd) begin
          st_d    = S_IDLE;
          end_smi = cfg[END_SMI_BIT];
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign trap      = use_trap & type_trap;
  assign pass_thru = acc_vld & ~trap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      smi_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      smi_q <= trap | end_smi;
    end
  end

  assign smi_pulse = smi_q;
  assign seq_busy  = (st_q != S_IDLE);

  AST_ENTRY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !seq_busy && acc_cmd_port && acc_wr && acc_data == GATE_CMD) |=> (seq_busy && !smi_pulse)); // R1
  AST_ENTRY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !seq_busy && acc_cmd_port && acc_wr && acc_data == GATE_CMD) |-> pass_thru); // R1
  AST_IDLE_DRD_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !seq_busy && !acc_cmd_port && !acc_wr && cfg[TRAP_DAT_RD]) |-> (!pass_thru ##1 smi_pulse)); // R2
  AST_GATE1_DWR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && st_q == S_GATE1 && !acc_cmd_port && acc_wr) |-> (pass_thru ##1 (seq_busy && !smi_pulse))); // R3
  AST_STATUS_RD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && seq_busy && acc_cmd_port && !acc_wr) |=> seq_busy); // R5
  AST_END_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && st_q == S_GATE2 && acc_cmd_port && acc_wr && acc_data == END_CMD) |-> (pass_thru ##1 !seq_busy)); // R6
  AST_NO_VLD_NO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |-> !pass_thru); // R8
  AST_NO_VLD_NO_SMI: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |=> (!smi_pulse && $stable(seq_busy))); // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!seq_busy && !smi_pulse)); // R9

endmodule

// File: tb/kbd_gate_trap_tb_top.sv
module kbd_gate_trap_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_vld = 1'b0, acc_cmd_port = 1'b0, acc_wr = 1'b0;
  logic [7:0] acc_data = 8'h00, cfg = 8'h00;
  logic       pass_thru, smi_pulse, seq_busy;

  int checks = 0, failures = 0, cycles = 0;
  int mstate = 0;

  typedef struct {
    logic  pass;
    logic  smi;
    logic  busy;
    string req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  kbd_gate_trap dut_i (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_cmd_port(acc_cmd_port),
    .acc_wr(acc_wr), .acc_data(acc_data), .cfg(cfg),
    .pass_thru(pass_thru), .smi_pulse(smi_pulse), .seq_busy(seq_busy));

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic access(bit cmdp, bit wr, logic [7:0] d, logic [7:0] c, string req);
    exp_t e;
    logic tb;
    int nxt;
    tb  = cmdp ? (wr ? c[3] : c[2]) : (wr ? c[1] : c[0]);
    nxt = mstate;
    e.req = req;
    case (mstate)
      0: if (cmdp && wr && d == 8'hD1) begin nxt = 1; e.pass = 1; e.smi = 0; end
         else begin e.pass = !tb; e.smi = tb; end
      1: if (!cmdp && wr) begin nxt = 2; e.pass = 1; e.smi = 0; end
         else if (cmdp && wr && d == 8'hD1) begin e.pass = 1; e.smi = 0; end
         else if (cmdp && !wr) begin e.pass = !tb; e.smi = tb; end
         else begin nxt = 0; e.pass = !tb; e.smi = tb | c[7]; end
      default:
         if (cmdp && wr && d == 8'hFF) begin nxt = 0; e.pass = 1; e.smi = c[7]; end
         else if (cmdp && !wr) begin e.pass = !tb; e.smi = tb; end
         else begin nxt = 0; e.pass = !tb; e.smi = tb | c[7]; end
    endcase
    mstate = nxt;
    e.busy = (nxt != 0);
    @(negedge clk);
    acc_vld = 1'b1; acc_cmd_port = cmdp; acc_wr = wr; acc_data = d; cfg = c;
    q.push_back(e);
  endtask

  task automatic quiet(int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.pass = 0; e.smi = 0; e.busy = (mstate != 0); e.req = "R8";
      @(negedge clk);
      acc_vld = 1'b0; acc_data = 8'hD1; cfg = 8'hFF;
      q.push_back(e);
    end
  endtask

  task automatic drain();
    quiet(1);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      exp_t e;
      wait (q.size() != 0);
      e = q[0];
      #1;
      check(e.req, "pass_thru", pass_thru, e.pass);
      @(posedge clk);
      #1;
      check(e.req, "smi_pulse", smi_pulse, e.smi);
      check(e.req, "seq_busy", seq_busy, e.busy);
      void'(q.pop_front());
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9", "reset busy", seq_busy, 1'b0);
    check("R9", "reset smi", smi_pulse, 1'b0);
    check("R8", "idle pass", pass_thru, 1'b0);

    // R2 idle accesses untrapped then trapped
    access(1, 1, 8'h20, 8'h00, "R2");
    access(1, 0, 8'h00, 8'h00, "R2");
    access(0, 1, 8'h55, 8'h00, "R2");
    access(0, 0, 8'h00, 8'h00, "R2");
    access(1, 1, 8'h20, 8'h08, "R2");
    access(1, 0, 8'h00, 8'h04, "R2");
    access(0, 1, 8'h55, 8'h02, "R2");
    access(0, 0, 8'h00, 8'h01, "R2");
    access(0, 0, 8'h00, 8'h0E, "R2");
    quiet(2);

    // full proper sequence with traps set
    access(1, 1, 8'hD1, 8'h0F, "R1");
    access(1, 1, 8'hD1, 8'h08, "R4");
    access(1, 0, 8'h00, 8'h04, "R5");
    access(0, 1, 8'hDF, 8'h02, "R3");
    access(1, 0, 8'h00, 8'h04, "R5");
    access(1, 0, 8'h00, 8'h00, "R5");
    access(1, 1, 8'hFF, 8'h8F, "R6");
    quiet(1);
    access(1, 1, 8'hD1, 8'h00, "R1");
    quiet(1);
    access(0, 1, 8'hDD, 8'h00, "R3");
    access(1, 1, 8'hFF, 8'h00, "R6");

    // R7 improper ends from first stage
    access(1, 1, 8'hD1, 8'h00, "R1");
    access(1, 1, 8'h20, 8'h80, "R7");
    access(1, 1, 8'hD1, 8'h00, "R1");
    access(0, 0, 8'h00, 8'h01, "R7");
    access(1, 1, 8'hD1, 8'h00, "R1");
    access(1, 1, 8'hAE, 8'h08, "R7");
    // R7 improper ends from second stage
    access(1, 1, 8'hD1, 8'h00, "R1");
    access(0, 1, 8'hDF, 8'h00, "R3");
    access(0, 1, 8'h11, 8'h82, "R7");
    access(1, 1, 8'hD1, 8'h00, "R1");
    access(0, 1, 8'hDF, 8'h00, "R3");
    access(0, 0, 8'h00, 8'h00, "R7");
    access(1, 1, 8'hD1, 8'h00, "R1");
    access(0, 1, 8'hDF, 8'h00, "R3");
    access(1, 1, 8'hD1, 8'h88, "R7");
    access(1, 1, 8'hD1, 8'h00, "R1");
    access(0, 1, 8'hDF, 8'h00, "R3");
    access(0, 0, 8'h00, 8'h80, "R7");
    quiet(3);

    // R9 reset in the middle of a sequence
    access(1, 1, 8'hD1, 8'h00, "R1");
    drain();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mstate = 0;
    #1;
    check("R9", "busy after mid reset", seq_busy, 1'b0);
    access(0, 1, 8'h33, 8'h00, "R9");
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule